// File: doc/BRIEF.md
# Condition-Code ALU with Carry-Coupled Rotates

This block is the execute stage of a small integer datapath. Each enabled cycle it takes two W-bit operands and a 4-bit operation code, computes one arithmetic, logic or shift/rotate result, and registers that result together with four condition flags. The flags are negative, zero, signed overflow and carry. Later conditional logic reads them from the flag outputs.

The carry flag is part of the datapath as well as a status bit. Add-with-carry adds the stored carry. Rotate-through-carry shifts the stored carry into bit 0. Plain rotate-left copies the bit that wraps around into carry. There is no separate carry input pin: the carry an operation consumes is always the one held in the flag register.

Results and flags change only on clock edges where the enable is high and the opcode is defined. Both registers clear to zero on reset.

Top module: `alu_flagged`

## Requirements
- R1: After reset is asserted, the result and all four flags read zero.
- R2: On an edge with `en_i` low, the result and all four flags keep their values, whatever the opcode and operands are.
- R3: Opcode 4'd0 (increment) registers a+1 and opcode 4'd1 (decrement) registers a-1, both modulo 2^W. For increment, carry is the carry out of the top bit and overflow is set only when a is the largest positive value. For decrement, carry is the borrow (set only when a is 0) and overflow is set only when a is the most negative value.
- R4: Opcode 4'd2 registers a+b modulo 2^W. Carry is the carry out of the top bit. Overflow is set when a and b have the same sign and the result's sign differs from it.
- R5: Opcode 4'd3 registers a+b+carry, using the carry flag held before the edge. Carry and overflow follow the R4 rules applied to the three-term sum.
- R6: Opcode 4'd4 registers the low W bits of the unsigned product a*b. Carry is set when the upper W bits of the product are nonzero. Overflow is cleared.
- R7: Opcodes 4'd5, 4'd6, 4'd7 and 4'd8 register a AND b, a OR b, a XOR b and NOT a, in that order. Each clears carry and overflow.
- R8: Opcode 4'd9 registers a shifted right by one with a zero in the top bit. Carry receives the old bit 0 of a. Overflow is cleared.
- R9: Opcode 4'd10 rotates a left by one. The old top bit of a goes into bit 0 and also into carry. Overflow is cleared.
- R10: Opcode 4'd11 rotates a left by one through carry. The old carry flag goes into bit 0 and the old top bit of a goes into carry. Overflow is cleared.
- R11: After every enabled operation with a defined opcode, negative equals the top bit of the result and zero is set exactly when the result is all zeros.
- R12: Opcodes 4'd12 to 4'd15 are undefined. On an enabled edge they leave the result and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Perform the operation on this edge |
| op_i | input | 4 | Operation code (encodings in R3 to R12) |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| result_o | output | W | Registered result |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Signed overflow flag |
| carry_o | output | 1 | Carry/borrow flag |

## Verification
The bench runs a 4-bit copy of the block. It sweeps every opcode against every pair of operands, once with carry preloaded to 0 and once with it preloaded to 1.

- A design that ignored the stored carry, or took it from the wrong edge, would give the wrong add-with-carry sum or the wrong rotate-through bit 0 in half of those cases.
- The wrap points catch borrow or overflow mistakes: increment of 0111, decrement of 0000 and 1000, and additions whose operands share a sign.
- Shift and rotate vectors with 1 in the end bits expose a swapped carry source.
- After each vector, an operation is applied with enable low. A design that leaked updates through the enable would change outputs that are expected to hold. The undefined opcodes test the same thing for R12.

// File: rtl/alu_flagged_pkg.sv
package alu_flagged_pkg;

    typedef enum logic [3:0] {
        OP_INC = 4'd0,
        OP_DEC = 4'd1,
        OP_ADD = 4'd2,
        OP_ADC = 4'd3,
        OP_MUL = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_NOT = 4'd8,
        OP_SHR = 4'd9,
        OP_ROL = 4'd10,
        OP_RCL = 4'd11
    } alu_op_e;

    localparam int unsigned OP_W     = 4;
    localparam int unsigned OP_COUNT = 12;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_flagged_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            cin_i,
    output logic [W-1:0]    res_o,
    output logic            cout_o,
    output logic            ovf_o,
    output logic            hit_o
);
    localparam int unsigned PW = 2 * W;

    logic [W:0]    sum;
    logic [PW-1:0] prod;
    logic          add_cin;

    always_comb begin
        prod    = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        add_cin = (op_i == OP_ADC) & cin_i;
        sum     = '0;
        res_o   = '0;
        cout_o  = 1'b0;
        ovf_o   = 1'b0;
        hit_o   = 1'b1;
        case (op_i)
            OP_INC: begin
                sum    = {1'b0, a_i} + (W+1)'(1);
                res_o  = sum[W-1:0];
                cout_o = sum[W];
                ovf_o  = ~a_i[W-1] & sum[W-1];
            end
            OP_DEC: begin
                sum    = {1'b0, a_i} - (W+1)'(1);
                res_o  = sum[W-1:0];
                cout_o = sum[W];
                ovf_o  = a_i[W-1] & ~sum[W-1];
            end
            OP_ADD, OP_ADC: begin
                sum    = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, add_cin};
                res_o  = sum[W-1:0];
                cout_o = sum[W];
                ovf_o  = (a_i[W-1] == b_i[W-1]) & (sum[W-1] != a_i[W-1]);
            end
            OP_MUL: begin
                res_o  = prod[W-1:0];
                cout_o = |prod[PW-1:W];
            end
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_flagged_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o,
    output logic            hit_o
);
    always_comb begin
        hit_o = 1'b1;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            default: begin
                res_o = '0;
                hit_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_flagged_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic            cin_i,
    output logic [W-1:0]    res_o,
    output logic            cout_o,
    output logic            hit_o
);
    logic [W-1:0] left_body;

    assign left_body = a_i << 1;

    always_comb begin
        res_o  = '0;
        cout_o = 1'b0;
        hit_o  = 1'b1;
        case (op_i)
            OP_SHR: begin
                res_o  = a_i >> 1;
                cout_o = a_i[0];
            end
            OP_ROL: begin
                res_o  = left_body | {{(W-1){1'b0}}, a_i[W-1]};
                cout_o = a_i[W-1];
            end
            OP_RCL: begin
                res_o  = left_body | {{(W-1){1'b0}}, cin_i};
                cout_o = a_i[W-1];
            end
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_flagged_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    result_o,
    output logic            neg_o,
    output logic            zero_o,
    output logic            ovf_o,
    output logic            carry_o
);
    typedef struct packed {
        logic [W-1:0] res;
        ccr_t         ccr;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0] ar_res, lg_res, sh_res;
    logic         ar_c, ar_v, ar_hit;
    logic         lg_hit;
    logic         sh_c, sh_hit;

    alu_arith #(.W(W)) i_arith (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (state_q.ccr.carry),
        .res_o (ar_res),
        .cout_o(ar_c),
        .ovf_o (ar_v),
        .hit_o (ar_hit)
    );

    alu_logic #(.W(W)) i_logic (
        .op_i (op_i),
        .a_i  (a_i),
        .b_i  (b_i),
        .res_o(lg_res),
        .hit_o(lg_hit)
    );

    alu_shift #(.W(W)) i_shift (
        .op_i  (op_i),
        .a_i   (a_i),
        .cin_i (state_q.ccr.carry),
        .res_o (sh_res),
        .cout_o(sh_c),
        .hit_o (sh_hit)
    );

    logic [W-1:0] sel_res;
    logic         sel_c, sel_v, sel_hit;

    always_comb begin
        sel_res = '0;
        sel_c   = 1'b0;
        sel_v   = 1'b0;
        sel_hit = ar_hit | lg_hit | sh_hit;
        if (ar_hit) begin
            sel_res = ar_res;
            sel_c   = ar_c;
            sel_v   = ar_v;
        end else if (lg_hit) begin
            sel_res = lg_res;
        end else if (sh_hit) begin
            sel_res = sh_res;
            sel_c   = sh_c;
        end

        state_d = state_q;
        if (en_i && sel_hit) begin
            state_d.res       = sel_res;
            state_d.ccr.neg   = sel_res[W-1];
            state_d.ccr.zero  = ~|sel_res;
            state_d.ccr.ovf   = sel_v;
            state_d.ccr.carry = sel_c;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign result_o = state_q.res;
    assign neg_o    = state_q.ccr.neg;
    assign zero_o   = state_q.ccr.zero;
    assign ovf_o    = state_q.ccr.ovf;
    assign carry_o  = state_q.ccr.carry;

endmodule

// File: rtl/alu_flagged_checker.sv
module alu_flagged_checker
    import alu_flagged_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [OP_W-1:0] op,
    input logic [W-1:0]    a,
    input logic [W-1:0]    b,
    input logic [W-1:0]    result,
    input logic            neg,
    input logic            zero,
    input logic            ovf,
    input logic            carry
);
    logic defined_op;
    logic logic_op;
    assign defined_op = op < OP_W'(OP_COUNT);
    assign logic_op   = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result) && $stable({neg, zero, ovf, carry}));

    p_add_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_ADD) |=> result == W'($past(a) + $past(b)));

    p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && logic_op) |=> !ovf && !carry);

    p_shr_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_SHR) |=> !result[W-1] && carry == $past(a[0]));

    p_rol_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_ROL) |=> result[0] == $past(a[W-1]) && carry == $past(a[W-1]));

    p_rcl_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_RCL) |=> result[0] == $past(carry) && carry == $past(a[W-1]));

    p_nz_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && defined_op) |=> neg == result[W-1] && zero == (result == '0));

    p_undef_noop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !defined_op) |=> $stable(result) && $stable({neg, zero, ovf, carry}));

endmodule

bind alu_flagged alu_flagged_checker #(.W(W)) i_checker (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .en    (en_i),
    .op    (op_i),
    .a     (a_i),
    .b     (b_i),
    .result(result_o),
    .neg   (neg_o),
    .zero  (zero_o),
    .ovf   (ovf_o),
    .carry (carry_o)
);

// File: tb/test_alu_flagged.sv
`timescale 1ns/1ps
module test_alu_flagged;
    localparam int W = 4;
    localparam int M = 1 << W;
    localparam int H = M / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [3:0]   op = '0;
    logic [W-1:0] a = '0, b = '0;
    logic [W-1:0] result;
    logic         neg, zero, ovf, carry;

    int checks = 0, fails = 0, cycles = 0;
    int exp_r = 0;
    bit exp_n = 0, exp_z = 0, exp_v = 0, exp_c = 0;

    always #2.5 clk = ~clk;

    alu_flagged #(.W(W)) i_alu_flagged (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .a_i(a), .b_i(b),
        .result_o(result), .neg_o(neg), .zero_o(zero), .ovf_o(ovf), .carry_o(carry)
    );

    function automatic int sv(input int x);
        return (x >= H) ? x - M : x;
    endfunction

    function automatic bit out_of_range(input int s);
        return (s < -H) || (s > H - 1);
    endfunction

    function automatic string tag_of(input int o, input bit e);
        if (!e) return "R2";
        case (o)
            0, 1:        return "R3";
            2:           return "R4";
            3:           return "R5";
            4:           return "R6";
            5, 6, 7, 8:  return "R7";
            9:           return "R8";
            10:          return "R9";
            11:          return "R10";
            default:     return "R12";
        endcase
    endfunction

    task automatic model(input int o, input int x, input int y);
        logic [W-1:0] xa, xb;
        int s, r;
        bit v, c;
        xa = W'(x);
        xb = W'(y);
        v = 0;
        c = 0;
        r = 0;
        case (o)
            0: begin s = x + 1; r = s % M; c = s >= M; v = out_of_range(sv(x) + 1); end
            1: begin r = (x + M - 1) % M; c = (x == 0); v = out_of_range(sv(x) - 1); end
            2: begin s = x + y; r = s % M; c = s >= M; v = out_of_range(sv(x) + sv(y)); end
            3: begin s = x + y + int'(exp_c); r = s % M; c = s >= M;
                     v = out_of_range(sv(x) + sv(y) + int'(exp_c)); end
            4: begin s = x * y; r = s % M; c = s >= M; end
            5: r = int'(xa & xb);
            6: r = int'(xa | xb);
            7: r = int'(xa ^ xb);
            8: r = M - 1 - x;
            9: begin r = x / 2; c = (x % 2) == 1; end
            10: begin r = (x * 2) % M + x / H; c = x >= H; end
            11: begin r = (x * 2) % M + int'(exp_c); c = x >= H; end
            default: ;
        endcase
        exp_r = r;
        exp_v = v;
        exp_c = c;
        exp_n = r >= H;
        exp_z = r == 0;
    endtask

    task automatic compare(input string tag, input int o, input int x, input int y);
        checks++;
        if (int'(result) != exp_r || ovf != exp_v || carry != exp_c) begin
            fails++;
            $display("FAIL %s op=%0d a=%0d b=%0d: got r=%0d v=%0b c=%0b, expected r=%0d v=%0b c=%0b",
                     tag, o, x, y, result, ovf, carry, exp_r, exp_v, exp_c);
        end
        checks++;
        if (neg != exp_n || zero != exp_z) begin
            fails++;
            $display("FAIL R11/%s op=%0d a=%0d b=%0d: got n=%0b z=%0b, expected n=%0b z=%0b",
                     tag, o, x, y, neg, zero, exp_n, exp_z);
        end
    endtask

    task automatic drive(input int o, input int x, input int y, input bit e);
        @(negedge clk);
        op = 4'(o);
        a = W'(x);
        b = W'(y);
        en = e;
        if (e && o < 12) model(o, x, y);
        @(negedge clk);
        en = 1'b0;
        compare(tag_of(o, e), o, x, y);
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        exp_r = 0; exp_n = 0; exp_z = 0; exp_v = 0; exp_c = 0;
        compare("R1", 0, 0, 0);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d cycles, expected at most 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        reset_check();
        // R1: reset also clears flags left set by earlier operations
        drive(2, M - 1, 1, 1'b1);
        reset_check();
        for (int o = 0; o < 16; o++) begin
            for (int x = 0; x < M; x++) begin
                for (int y = 0; y < M; y++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        // preload carry: (M-1)+ci carries out only when ci is 1
                        drive(2, M - 1, ci, 1'b1);
                        drive(o, x, y, 1'b1);
                        // R2: a disabled operation must leave everything as it was
                        drive((o + 3) % 16, x ^ 5, y ^ 3, 1'b0);
                    end
                end
            end
        end
        reset_check();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule